// File: doc/BRIEF.md
# Multi-Mode Host Register Bus Slave

This block is the slave end of a host processor's register bus. The processor uses it to read and write a bank of control registers and two small buffer memories: a link-layer message buffer and a trace buffer. A static mode input selects one of three bus styles. Two of them are asynchronous: one has separate read and write strobes, the other has a data strobe plus a read/write level. The third is a synchronous bus with a transfer-start qualifier sampled on the rising edge of the block clock.

When the block decodes a transfer, it counts out a programmable number of wait states. It then drives one completion pin. The meaning and polarity of that pin depend on the mode. In the two asynchronous modes it is an active-low ready or transfer acknowledge, and the host stretches its cycle until the pin goes low. In the synchronous mode it is an active-high ready that lasts one clock cycle. Read data is presented when completion asserts and is held afterwards.

The mode and wait-state inputs are meant to be static. The bench changes them only while the block is idle.

Top module: `hostbus_slave`

## Requirements
- R1: While `cs_n` is high, no transfer starts. The completion pin stays inactive and no storage location changes, whatever the strobes do.
- R2: `mode` 0 selects split-strobe asynchronous, 1 selects data-strobe asynchronous, and 2 or 3 selects synchronous. The inactive level of `ack_pin` is high in modes 0 and 1 and low in the synchronous mode.
- R3: In mode 0, `rd_n` low starts a read and `wr_n` low starts a write. When both are low, the read is taken.
- R4: In mode 1, `ds_n` low starts a transfer. `rnw` high means read and `rnw` low means write.
- R5: In the synchronous mode, `cs_n` and `ts_n` both low at a rising edge start a transfer, with `rnw` giving the direction. `ack_pin` goes high `wait_cfg`+1 edges after that sampling edge and stays high for exactly one cycle.
- R6: In asynchronous modes, strobes and chip select pass through two flops. Counting the first rising edge after the request appears as edge 1, `ack_pin` goes low on edge `wait_cfg`+4. It stays low while the host holds the request, and returns high on the third edge after the host releases it.
- R7: `wait_cfg` (0 to 7) adds exactly that many clock cycles between request capture and completion.
- R8: A write lands in storage on the same edge at which completion asserts. Read data appears on `rdata` on that edge and stays unchanged until the next read completes.
- R9: Once a transfer is captured, further strobes are ignored until that transfer has completed and been released.
- R10: `addr[7:6]` picks the region: 0 = eight control registers indexed by `addr[2:0]`, 1 = 16-word message buffer indexed by `addr[3:0]`, 2 = 16-word trace buffer indexed by `addr[3:0]`, 3 = unmapped (reads return 0, writes are dropped). Any other address bits are ignored.
- R11: After reset, all storage reads as zero, `rdata` is zero and `ack_pin` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Bus style select (static) |
| wait_cfg | input | 3 | Wait states inserted before completion |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe, mode 0 |
| wr_n | input | 1 | Active-low write strobe, mode 0 |
| ds_n | input | 1 | Active-low data strobe, mode 1 |
| rnw | input | 1 | Direction level, high = read (modes 1 and synchronous) |
| ts_n | input | 1 | Active-low transfer start, synchronous mode |
| addr | input | 8 | Register or buffer address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, held between reads |
| ack_pin | output | 1 | Completion handshake, polarity per mode |

## Verification
Suppose the transfer state machine ends up in the wrong state. The port effect is a completion pin that fires a cycle early or late, or that never releases. In the synchronous mode it shows as a pulse wider than one cycle. All of these are seen in the first transfer, because every transfer's edge count is checked. A wrong captured address or direction shows up later, when a read returns a word that differs from the bench's shadow of storage. Dropping strobes while busy is checked by the next read of the address the rejected strobe named.

// File: rtl/hbs_pkg.sv
// Package: shared types for the host bus slave.
// Holds the bus-mode codes, the transfer state encoding and the region codes.
package hbs_pkg;

    typedef enum logic [1:0] {
        BUS_SPLIT = 2'd0,
        BUS_DSTRB = 2'd1,
        BUS_SYNC  = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_e;

    localparam logic [1:0] RGN_CTRL = 2'd0;
    localparam logic [1:0] RGN_MSG  = 2'd1;
    localparam logic [1:0] RGN_TRC  = 2'd2;

endpackage

// File: rtl/hbs_sync.sv
// Module: hbs_sync
// Two-flop synchronizer for a vector of active-low bus controls.
// Assumes each bit is an independent level; after reset the outputs read all ones (inactive).
module hbs_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    // Shift the asynchronous inputs through two clocked stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            d_out  <= '1;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/hbs_bank.sv
// Module: hbs_bank
// One storage bank with a combinational read port and a clocked write port.
// Assumes DEPTH is a power of two no smaller than two.
module hbs_bank #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Read the addressed word without delay.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/hbs_store.sv
// Module: hbs_store
// Address decoder over three banks: control registers, message buffer and trace buffer.
// The top two address bits pick the bank, and the fourth region is unmapped.
// Assumes every depth is a power of two that fits below the region bits.
module hbs_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int REG_N  = 8,
    parameter int MSG_N  = 16,
    parameter int TRC_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    import hbs_pkg::*;

    localparam int NBANK = 3;

    logic [1:0]        region;
    logic [DATA_W-1:0] bank_q [NBANK];

    // Region select from the top address bits.
    always_comb region = addr[ADDR_W-1 -: 2];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int D  = (g == 0) ? REG_N : ((g == 1) ? MSG_N : TRC_N);
        localparam int IW = $clog2(D);
        hbs_bank #(.DEPTH(D), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we && (region == 2'(g))),
            .idx   (addr[IW-1:0]),
            .wdata (wdata),
            .rdata (bank_q[g])
        );
    end

    // Select the read word; the unmapped region reads as zero.
    always_comb begin
        case (region)
            RGN_CTRL: rd_word = bank_q[0];
            RGN_MSG:  rd_word = bank_q[1];
            RGN_TRC:  rd_word = bank_q[2];
            default:  rd_word = '0;
        endcase
    end
endmodule

// File: rtl/hbs_ctrl.sv
// Module: hbs_ctrl
// Transfer sequencer: captures a decoded request, counts the wait states,
// raises completion, loads or commits data, and drops completion again.
// Assumes req is already in the clock domain and that wait_cfg is static while busy.
module hbs_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              req,
    input  logic              is_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic              ack_q,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_wdata,
    output logic [DATA_W-1:0] rdata
);
    import hbs_pkg::*;

    xfer_state_e       state;
    logic [WAIT_W-1:0] cnt;
    logic              cap_rd;
    logic              last_wait;

    // Last wait cycle: completion is raised on the next edge.
    always_comb last_wait = (state == ST_WAIT) && (cnt == '0);

    // Write strobe to storage, aligned with the rise of completion.
    always_comb we = last_wait && !cap_rd;

    // Transfer in progress.
    always_comb busy = (state != ST_IDLE);

    // Sequence each transfer from capture through completion and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ack_q     <= 1'b0;
            cap_rd    <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            rdata     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        cap_addr  <= addr;
                        cap_wdata <= wdata;
                        cap_rd    <= is_rd;
                        cnt       <= wait_cfg;
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        ack_q <= 1'b1;
                        state <= ST_DONE;
                        if (cap_rd) rdata <= rd_word;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (sync_mode || !req) begin
                        ack_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hostbus_slave.sv
// Module: hostbus_slave
// Host register bus slave with three bus styles and one mode-dependent completion pin.
// Assumes mode is static, and that the host holds address and write data
// stable while its strobe is active in the asynchronous modes.
module hostbus_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 3,
    parameter int REG_N  = 8,
    parameter int MSG_N  = 16,
    parameter int TRC_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              ds_n,
    input  logic              rnw,
    input  logic              ts_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack_pin
);
    import hbs_pkg::*;

    localparam int NSYNC = 5;

    logic [NSYNC-1:0]  s_ctl;
    logic              s_cs_n, s_rd_n, s_wr_n, s_ds_n, s_rnw;
    logic              sync_mode;
    logic              req, is_rd;
    logic              ack_q, busy, we;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] rd_word;

    hbs_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, rd_n, wr_n, ds_n, rnw}),
        .d_out (s_ctl)
    );

    // Unpack the synchronized controls.
    always_comb {s_cs_n, s_rd_n, s_wr_n, s_ds_n, s_rnw} = s_ctl;

    // Modes 2 and 3 are the synchronous bus.
    always_comb sync_mode = mode[1];

    // Per-mode strobe decode into one request and one direction.
    always_comb begin
        if (sync_mode) begin
            req   = !cs_n && !ts_n;
            is_rd = rnw;
        end else if (mode == BUS_SPLIT) begin
            req   = !s_cs_n && (!s_rd_n || !s_wr_n);
            is_rd = !s_rd_n;
        end else begin
            req   = !s_cs_n && !s_ds_n;
            is_rd = s_rnw;
        end
    end

    hbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .wait_cfg  (wait_cfg),
        .req       (req),
        .is_rd     (is_rd),
        .addr      (addr),
        .wdata     (wdata),
        .rd_word   (rd_word),
        .ack_q     (ack_q),
        .busy      (busy),
        .we        (we),
        .cap_addr  (cap_addr),
        .cap_wdata (cap_wdata),
        .rdata     (rdata)
    );

    hbs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_N(REG_N),
                .MSG_N(MSG_N), .TRC_N(TRC_N)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .addr    (cap_addr),
        .wdata   (cap_wdata),
        .rd_word (rd_word)
    );

    // Completion polarity: active high on the synchronous bus, active low otherwise.
    always_comb ack_pin = sync_mode ? ack_q : !ack_q;
endmodule

// File: rtl/hbs_checker.sv
// Module: hbs_checker
// Temporal checks on the host bus slave, attached to the top module by bind.
// Assumes wait_cfg does not change during a transfer.
module hbs_checker #(
    parameter int DATA_W = 16,
    parameter int WAIT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic              ack_q,
    input logic              busy,
    input logic              we,
    input logic              req,
    input logic [DATA_W-1:0] rdata
);
    logic [WAIT_W:0] wcnt;

    // Count the busy cycles that precede completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) wcnt <= '0;
        else if (!ack_q)     wcnt <= wcnt + 1'b1;
    end

    // R5
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && ack_q) |=> !ack_q);

    // R6
    async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && ack_q && req) |=> ack_q);

    // R8
    commit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $rose(ack_q));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ack_q) |-> $stable(rdata));

    // R7
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> (wcnt == ({1'b0, wait_cfg} + 1'b1)));
endmodule

bind hostbus_slave hbs_checker #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .wait_cfg (wait_cfg),
    .ack_q    (ack_q),
    .busy     (busy),
    .we       (we),
    .req      (req),
    .rdata    (rdata)
);

// File: tb/sim_hostbus_slave.sv
// Bench: sim_hostbus_slave
// Directed corner cases plus seeded random transfers, checked against a shadow of storage.
module sim_hostbus_slave;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  wait_cfg = 3'd0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rnw = 1'b1, ts_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack_pin;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_reg [8];
    logic [15:0] m_msg [16];
    logic [15:0] m_trc [16];
    logic [15:0] last_rd = '0;

    always #(CLK_P/2) clk = ~clk;

    hostbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wait_cfg(wait_cfg),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rnw(rnw), .ts_n(ts_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack_pin(ack_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected read value from the region map (R10).
    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        case (a[7:6])
            2'd0:    return m_reg[a[2:0]];
            2'd1:    return m_msg[a[3:0]];
            2'd2:    return m_trc[a[3:0]];
            default: return 16'h0;
        endcase
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [15:0] d);
        case (a[7:6])
            2'd0:    m_reg[a[2:0]] = d;
            2'd1:    m_msg[a[3:0]] = d;
            2'd2:    m_trc[a[3:0]] = d;
            default: ;
        endcase
    endfunction

    function automatic bit active(input int m);
        return (m >= 2) ? ack_pin : !ack_pin;
    endfunction

    task automatic release_all();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1; ts_n = 1'b1; rnw = 1'b1;
    endtask

    // One complete transfer; entered and left at a falling edge.
    task automatic xfer(input int m, input bit rd, input logic [7:0] a,
                        input logic [15:0] d, input int w, input bit both);
        int n = 0;
        bit got = 0;
        logic [15:0] exp = exp_rd(a);
        mode = 2'(m); wait_cfg = 3'(w); addr = a; wdata = d; cs_n = 1'b0;
        if (m >= 2) begin ts_n = 1'b0; rnw = rd; end
        else if (m == 0) begin rd_n = !rd; wr_n = rd && !both; end
        else begin ds_n = 1'b0; rnw = rd; end
        while (!got && n < 40) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (m >= 2 && n == 1) release_all();
            if (active(m)) got = 1;
        end
        if (m >= 2) chk(n == w + 2, "R5 sync latency", n, w + 2);
        else        chk(n == w + 4, "R6 async latency", n, w + 4);
        if (rd) begin
            chk(rdata == exp, (m == 0) ? "R3 read data" : ((m == 1) ? "R4 read data" : "R10 read data"), rdata, exp);
            last_rd = exp;
        end else begin
            model_wr(a, d);
            chk(rdata == last_rd, "R8 rdata held over write", rdata, last_rd);
        end
        if (m >= 2) begin
            @(posedge clk); @(negedge clk);
            chk(!active(m), "R5 one-cycle pulse", ack_pin, 0);
        end else begin
            repeat (2) begin
                @(posedge clk); @(negedge clk);
                chk(active(m), "R6 held while requested", ack_pin, 0);
            end
            release_all();
            n = 0;
            while (active(m) && n < 20) begin
                @(posedge clk); n++; @(negedge clk);
            end
            chk(n == 3, "R6 release latency", n, 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        for (int i = 0; i < 16; i++) begin m_msg[i] = '0; m_trc[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state; R2 idle polarity per mode
        chk(ack_pin == 1'b1, "R11 ack inactive after reset", ack_pin, 1);
        chk(rdata == 16'h0, "R11 rdata zero after reset", rdata, 0);
        mode = 2'd2; #1;
        chk(ack_pin == 1'b0, "R2 sync idle level low", ack_pin, 0);
        mode = 2'd1; #1;
        chk(ack_pin == 1'b1, "R2 strobe idle level high", ack_pin, 1);
        @(negedge clk);
        xfer(1, 1, 8'h45, 16'h0, 0, 0);          // R11 storage reads zero

        // R3, R4, R5, R10 directed: writes in each mode, read back
        xfer(0, 0, 8'h03, 16'hA5A5, 0, 0);
        xfer(1, 0, 8'h4F, 16'h1234, 7, 0);
        xfer(2, 0, 8'h8E, 16'hBEEF, 3, 0);
        xfer(3, 1, 8'h03, 16'h0, 0, 0);
        xfer(0, 1, 8'h4F, 16'h0, 2, 0);
        xfer(1, 1, 8'h8E, 16'h0, 5, 0);
        // R10 unmapped region and alias of upper index bits
        xfer(2, 0, 8'hC1, 16'hFFFF, 0, 0);
        xfer(2, 1, 8'hC1, 16'h0, 0, 0);
        xfer(0, 0, 8'h3B, 16'h7777, 1, 0);
        xfer(2, 1, 8'h03, 16'h0, 1, 0);
        // R3 both strobes low: the read is taken, storage unchanged
        xfer(0, 1, 8'h03, 16'h9999, 0, 1);
        xfer(2, 1, 8'h03, 16'h0, 0, 0);

        // R1 chip select high: no completion and no write, both styles
        mode = 2'd0; wait_cfg = 3'd0; addr = 8'h03; wdata = 16'hDEAD;
        cs_n = 1'b1; wr_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 9) chk(ack_pin == 1'b1, "R1 no ack without select", ack_pin, 1);
        end
        release_all();
        mode = 2'd2; ts_n = 1'b0;
        @(posedge clk); @(negedge clk);
        ts_n = 1'b1;
        repeat (12) begin @(posedge clk); @(negedge clk); end
        chk(ack_pin == 1'b0, "R1 no sync ack without select", ack_pin, 0);
        repeat (4) begin @(posedge clk); @(negedge clk); end
        xfer(2, 1, 8'h03, 16'h0, 0, 0);

        // R9 second start while busy is dropped
        mode = 2'd2; wait_cfg = 3'd5; addr = 8'h41; wdata = 16'h1111; rnw = 1'b0;
        cs_n = 1'b0; ts_n = 1'b0;
        @(posedge clk); @(negedge clk);
        release_all();
        model_wr(8'h41, 16'h1111);
        @(posedge clk); @(negedge clk);
        addr = 8'h42; wdata = 16'h2222; rnw = 1'b0; cs_n = 1'b0; ts_n = 1'b0;
        @(posedge clk); @(negedge clk);
        release_all();
        repeat (8) begin @(posedge clk); @(negedge clk); end
        xfer(2, 1, 8'h42, 16'h0, 0, 0);
        chk(rdata == 16'h0, "R9 busy strobe ignored", rdata, 0);
        xfer(2, 1, 8'h41, 16'h0, 0, 0);

        // R7 random mix over every mode and wait setting
        for (int t = 0; t < 80; t++) begin
            int m = int'($urandom_range(0, 3));
            bit rd = 1'($urandom_range(0, 1));
            logic [7:0] a = 8'($urandom);
            logic [15:0] d = 16'($urandom);
            int w = int'($urandom_range(0, 7));
            xfer(m, rd, a, d, w, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule